// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block links two equal-width buses, A and B, and can pass data from either one to the other. Each direction has its own storage register with its own clock. The A-side register samples bus A, and the B-side register samples bus B. An active-low output enable and a direction input decide which bus the block drives, if any. For each direction, a select input chooses what the driven bus carries: the live value of the opposite bus, or the register holding that bus's earlier value.

The pins are not modelled as tri-state wires. Each bus appears as three ports: an input vector, an output vector, and a single output-enable bit that is high while the block drives that bus. A parameter chooses a true or a complemented output path. The control behaviour is the same in both variants. The registers keep sampling while both buses are isolated, so a host can capture A and B data without driving anything.

Top module: `regbus_xcvr`

## Requirements
- R1: A rising edge of a register's clock while `rst_n` is low clears that register to zero.
- R2: While `oe_n` is high, `a_oe` and `b_oe` are both low.
- R3: With `oe_n` low, `dir` high sets `b_oe` high and `a_oe` low. With `oe_n` low, `dir` low sets `a_oe` high and `b_oe` low.
- R4: `a_oe` and `b_oe` are never high together.
- R5: With `sel_ab` low, `b_out` equals `a_in`. With `sel_ab` high, `b_out` equals the A-side register. Both values pass through the output polarity of R10.
- R6: With `sel_ba` low, `a_out` equals `b_in`. With `sel_ba` high, `a_out` equals the B-side register. Both values pass through the output polarity of R10.
- R7: On each rising edge of `clk_ab` with `rst_n` high, the A-side register loads the resolved A pin value: `a_out` when `a_oe` is high, `a_in` otherwise. Between edges it holds its value.
- R8: On each rising edge of `clk_ba` with `rst_n` high, the B-side register loads the resolved B pin value: `b_out` when `b_oe` is high, `b_in` otherwise. Between edges it holds its value.
- R9: Both registers capture on their clock edges while `oe_n` is high. Data stored while isolated appears later on the stored path.
- R10: With `INVERT` set to 1, `a_out` and `b_out` carry the bitwise complement of the selected value. The control behaviour of R2 to R4 and the capture rules of R7 and R8 are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ab | input | 1 | Capture clock of the A-side register |
| clk_ba | input | 1 | Capture clock of the B-side register |
| rst_n | input | 1 | Active-low reset, synchronous to each register's own clock |
| oe_n | input | 1 | Active-low output enable |
| dir | input | 1 | 1: drive bus B; 0: drive bus A |
| sel_ab | input | 1 | Source of B outputs: 0 live A, 1 stored A |
| sel_ba | input | 1 | Source of A outputs: 0 live B, 1 stored B |
| a_in | input | WIDTH | Value present on bus A |
| a_out | output | WIDTH | Data driven onto bus A |
| a_oe | output | 1 | High while bus A is driven |
| b_in | input | WIDTH | Value present on bus B |
| b_out | output | WIDTH | Data driven onto bus B |
| b_oe | output | 1 | High while bus B is driven |

## Verification
The bench builds two copies of the block with the default 8-bit width: one with `INVERT` = 0 and one with `INVERT` = 1. Both copies receive the same stimulus. The complemented copy shows that inversion reaches only the driven data. When a register samples its own driven bus, the complemented copy loads the inverted value, which the true copy cannot show. The stimulus covers all sixteen settings of enable, direction and the two selects, with each clock gated on or off. This reaches isolated storage, hold between edges, and self-capture on a driven bus.

// File: rtl/regbus_xcvr_pkg.sv
// Shared types for the registered bus transceiver.
package regbus_xcvr_pkg;
    // Which bus, if any, the block is driving.
    typedef enum logic [1:0] {
        SIDE_NONE = 2'b00,
        SIDE_A    = 2'b01,
        SIDE_B    = 2'b10
    } drive_side_e;
endpackage

// File: rtl/xcvr_ctrl.sv
// Decodes enable and direction into the side being driven.
// Assumes: oe_n is active low; at most one side is ever selected.
module xcvr_ctrl
    import regbus_xcvr_pkg::*;
(
    input  logic        oe_n,
    input  logic        dir,
    output drive_side_e side
);
    // Pick the driven side from the enable and direction inputs.
    always_comb begin
        if (oe_n)     side = SIDE_NONE;
        else if (dir) side = SIDE_B;
        else          side = SIDE_A;
    end
endmodule

// File: rtl/xcvr_store.sv
// One direction's storage register, loaded on every rising edge of its clock.
// Assumes: reset is synchronous and active low on this register's own clock.
module xcvr_store #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    // Capture the resolved pin value, or clear while in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R1: an edge taken in reset leaves the register cleared
    a_r1_clear: assert property (@(posedge clk) !rst_n |=> q == '0);
    // R7 for the A instance, R8 for the B instance: capture on every edge
    a_r7_capture: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> q == $past(d));
endmodule

// File: rtl/xcvr_drive.sv
// Output data path for one direction: live/stored select and optional complement.
// Assumes: INVERT is 0 (true path) or 1 (complemented path).
module xcvr_drive #(
    parameter int WIDTH  = 8,
    parameter bit INVERT = 1'b0
) (
    input  logic             sel_stored,
    input  logic [WIDTH-1:0] live,
    input  logic [WIDTH-1:0] stored,
    output logic [WIDTH-1:0] out
);
    logic [WIDTH-1:0] picked;

    // Choose between the live opposite bus and the stored register.
    always_comb picked = sel_stored ? stored : live;

    generate
        if (INVERT) begin : g_inv
            // Complement the selected value on its way to the pins.
            always_comb out = ~picked;
        end else begin : g_true
            // Pass the selected value straight to the pins.
            always_comb out = picked;
        end
    endgenerate
endmodule

// File: rtl/regbus_xcvr.sv
// Registered bidirectional transceiver between buses A and B.
// Each direction has its own register and clock; one bus at most is driven.
// Assumes: a bus's pin value is its output while driven, else its input.
module regbus_xcvr
    import regbus_xcvr_pkg::*;
#(
    parameter int WIDTH  = 8,
    parameter bit INVERT = 1'b0
) (
    input  logic             clk_ab,
    input  logic             clk_ba,
    input  logic             rst_n,
    input  logic             oe_n,
    input  logic             dir,
    input  logic             sel_ab,
    input  logic             sel_ba,
    input  logic [WIDTH-1:0] a_in,
    output logic [WIDTH-1:0] a_out,
    output logic             a_oe,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] b_out,
    output logic             b_oe
);
    localparam logic [WIDTH-1:0] POL_MASK = INVERT ? {WIDTH{1'b1}} : '0;

    drive_side_e      side;
    logic [WIDTH-1:0] a_pin, b_pin, reg_a, reg_b;

    xcvr_ctrl u_ctrl (.oe_n(oe_n), .dir(dir), .side(side));

    // Turn the decoded side into the two per-bus enables.
    always_comb begin
        a_oe = (side == SIDE_A);
        b_oe = (side == SIDE_B);
    end

    // Resolve each bus's pin value as the register sees it.
    always_comb begin
        a_pin = a_oe ? a_out : a_in;
        b_pin = b_oe ? b_out : b_in;
    end

    xcvr_store #(.WIDTH(WIDTH)) u_store_a (.clk(clk_ab), .rst_n(rst_n), .d(a_pin), .q(reg_a));
    xcvr_store #(.WIDTH(WIDTH)) u_store_b (.clk(clk_ba), .rst_n(rst_n), .d(b_pin), .q(reg_b));

    xcvr_drive #(.WIDTH(WIDTH), .INVERT(INVERT)) u_drive_b
        (.sel_stored(sel_ab), .live(a_in), .stored(reg_a), .out(b_out));
    xcvr_drive #(.WIDTH(WIDTH), .INVERT(INVERT)) u_drive_a
        (.sel_stored(sel_ba), .live(b_in), .stored(reg_b), .out(a_out));

    // Port-level checks on enables and live paths.
    always_comb begin
        if (!$isunknown({a_oe, b_oe}))
            a_r4_exclusive: assert (!(a_oe && b_oe));
        if (!$isunknown({oe_n, a_oe, b_oe}) && oe_n)
            a_r2_isolate: assert (!a_oe && !b_oe);
        if (!$isunknown({oe_n, dir, a_oe, b_oe}) && !oe_n)
            a_r3_direction: assert (b_oe == dir && a_oe == !dir);
        if (!$isunknown({sel_ab, a_in, b_out}) && !sel_ab)
            a_r5_live: assert (b_out == (a_in ^ POL_MASK));
        if (!$isunknown({sel_ba, b_in, a_out}) && !sel_ba)
            a_r6_live: assert (a_out == (b_in ^ POL_MASK));
    end
endmodule

// File: tb/regbus_xcvr_tb_top.sv
// Bench: two copies (true and complemented) against a behavioural model.
module regbus_xcvr_tb_top;
    localparam int W = 8;

    logic clk = 1'b0;
    logic gate_ab = 1'b0, gate_ba = 1'b0;
    logic clk_ab, clk_ba;
    logic rst_n = 1'b0, oe_n = 1'b1, dir = 1'b0, sel_ab = 1'b0, sel_ba = 1'b0;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic [W-1:0] ao0, bo0, ao1, bo1;
    logic aoe0, boe0, aoe1, boe1;
    int errors = 0, checks = 0;
    bit finished = 1'b0;
    string tag = "R1";

    // Model state: stored A and B values for each variant (index = INVERT).
    logic [W-1:0] m_ra [2];
    logic [W-1:0] m_rb [2];

    always #2 clk = ~clk;
    assign clk_ab = clk & gate_ab;
    assign clk_ba = clk & gate_ba;

    regbus_xcvr #(.WIDTH(W), .INVERT(1'b0)) dut_i (
        .clk_ab(clk_ab), .clk_ba(clk_ba), .rst_n(rst_n), .oe_n(oe_n), .dir(dir),
        .sel_ab(sel_ab), .sel_ba(sel_ba), .a_in(a_in), .a_out(ao0), .a_oe(aoe0),
        .b_in(b_in), .b_out(bo0), .b_oe(boe0));
    regbus_xcvr #(.WIDTH(W), .INVERT(1'b1)) dut_inv_i (
        .clk_ab(clk_ab), .clk_ba(clk_ba), .rst_n(rst_n), .oe_n(oe_n), .dir(dir),
        .sel_ab(sel_ab), .sel_ba(sel_ba), .a_in(a_in), .a_out(ao1), .a_oe(aoe1),
        .b_in(b_in), .b_out(bo1), .b_oe(boe1));

    function automatic logic [W-1:0] exp_bout(int v);
        logic [W-1:0] x = sel_ab ? m_ra[v] : a_in;
        return v ? ~x : x;
    endfunction
    function automatic logic [W-1:0] exp_aout(int v);
        logic [W-1:0] x = sel_ba ? m_rb[v] : b_in;
        return v ? ~x : x;
    endfunction

    // Model registers: resolved pin value on each gated edge.
    always @(posedge clk) begin
        for (int v = 0; v < 2; v++) begin
            logic aoe_m, boe_m;
            logic [W-1:0] na, nb;
            aoe_m = !oe_n && !dir;
            boe_m = !oe_n && dir;
            na = !rst_n ? '0 : (aoe_m ? exp_aout(v) : a_in);
            nb = !rst_n ? '0 : (boe_m ? exp_bout(v) : b_in);
            if (gate_ab) m_ra[v] <= na;
            if (gate_ba) m_rb[v] <= nb;
        end
    end

    task automatic chk(input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Compare both copies with the model; called away from the clock edge.
    task automatic compare();
        logic eaoe, eboe;
        eaoe = !oe_n && !dir;
        eboe = !oe_n && dir;
        chk("a_oe", W'(aoe0), W'(eaoe));
        chk("b_oe", W'(boe0), W'(eboe));
        chk("R4 both driven", W'(aoe0 & boe0), '0);
        chk("a_out", ao0, exp_aout(0));
        chk("b_out", bo0, exp_bout(0));
        chk("R10 a_oe inv", W'(aoe1), W'(eaoe));
        chk("R10 b_oe inv", W'(boe1), W'(eboe));
        chk("R10 a_out inv", ao1, exp_aout(1));
        chk("R10 b_out inv", bo1, exp_bout(1));
    endtask

    task automatic step(input string t, input logic on, input logic dr, input logic sab,
                        input logic sba, input logic ga, input logic gb,
                        input logic [W-1:0] av, input logic [W-1:0] bv);
        tag = t;
        oe_n = on; dir = dr; sel_ab = sab; sel_ba = sba;
        gate_ab = ga; gate_ba = gb; a_in = av; b_in = bv;
        @(negedge clk);
        compare();
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1: clock both registers in reset, then read them on the stored paths.
        rst_n = 1'b0;
        step("R1", 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'hFF, 8'hFF);
        step("R1", 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'hFF, 8'hFF);
        rst_n = 1'b1;
        step("R1", 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h11, 8'h22);
        step("R1", 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h11, 8'h22);
        // R9: store both buses while isolated, then show them on stored paths.
        step("R9", 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'h5A, 8'hC3);
        step("R9", 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00);
        step("R9", 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00);
        step("R9", 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00);
        // R7 and R8: hold between edges, then load only the clocked side.
        step("R7,R8 hold", 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'hA5, 8'h3C);
        step("R7 load", 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 8'h96, 8'h69);
        step("R7 load", 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00);
        step("R8 load", 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 8'h0F, 8'hF0);
        step("R8 load", 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00);
        // R7/R8 self-capture: a register samples its own driven bus.
        step("R7 self", 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 8'h3E);
        step("R7 self", 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00);
        step("R8 self", 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'hD2, 8'h00);
        step("R8 self", 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00);
        // R2,R3,R5,R6: every enable/direction/select setting, several patterns.
        for (int rep = 0; rep < 24; rep++) begin
            for (int c = 0; c < 16; c++) begin
                string t;
                logic [3:0] cc = 4'(c);
                t = cc[3] ? "R2,R9" : (cc[2] ? "R3,R5" : "R3,R6");
                step(t, cc[3], cc[2], cc[1], cc[0], 1'($urandom), 1'($urandom),
                     8'($urandom), 8'($urandom));
            end
        end
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule